// File: doc/BRIEF.md
# Parallel Tag-Data Line Cache

This block is a line cache that holds whole lines. The tag store and the line data store are addressed in the same cycle, so every command finishes in one clock. Four control bits (request, read/write, invalidate, replace) select one command per cycle from a small set: look up and read a line, overwrite a line, read or write a line and then drop it, or install a new line in place of an old one. Results come out of registers one cycle after the command.

The default build holds 32 lines of 32 bits under 8-bit line addresses and is fully associative with least-recently-used replacement. An address carries no word or byte select bits. The line store reads before it writes, so any command that writes a line also returns the content that was there before. A replace returns the evicted line and its tag in the same step. The block does not talk to a backing memory and has no refill sequence.

Top module: `lcache_par`

## Requirements
- R1: After reset, hit_o, miss_o, line_o and old_addr_o are zero and every line is invalid. A request to any address therefore misses, and stored tags read as zero.
- R2: Commands are encoded as {req_i, rw_i, inv_i, rep_i}:
  - 1000 is read.
  - 1100 is update.
  - 1010 is read and drop.
  - 1110 is write and drop.
  - 0001 is replace.
  - Every other value is idle. An idle value raises no flag, drives no new data and changes no state.
- R3: For each request, exactly one of hit_o and miss_o is 1 in the next cycle, and that flag reflects whether the address was valid in the cache. In a cycle after a non-request, both flags are 0.
- R4: A read that hits drives the stored line on line_o one cycle later. line_o keeps its value after any cycle with no hitting request and no replace.
- R5: An update that hits stores line_i in that line and, one cycle later, drives the line's previous content on line_o.
- R6: Read-and-drop and write-and-drop that hit drive the previous content on line_o one cycle later and make the address miss afterwards. Write-and-drop also stores line_i, and a later replace that evicts that line returns the written value.
- R7: A replace stores line_i under addr_i and marks the line valid. One cycle later it drives the evicted content on line_o and the evicted tag on old_addr_o. A replace raises neither flag. old_addr_o changes only on a replace.
- R8: A replace picks the lowest-numbered invalid line when one exists, so lines fill from 0 upward after reset.
- R9: When every line is valid, a replace evicts the least recently used line. Read, update and replace make their line the most recently used. The drop commands make their line the least recently used.
- R10: A replace whose address is already present reuses that same line: old_addr_o equals addr_i and no other line is evicted.
- R11: A request that misses changes no line, no tag and no usage order, and it does not allocate a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request bit of the command |
| rw_i | input | 1 | Write selector of the command |
| inv_i | input | 1 | Drop selector of the command |
| rep_i | input | 1 | Replace bit of the command |
| addr_i | input | ADDR_W | Line address (no word/byte bits) |
| line_i | input | LINE_W | New line content for writes and replaces |
| line_o | output | LINE_W | Line content, registered |
| hit_o | output | 1 | Registered hit flag for a request |
| miss_o | output | 1 | Registered miss flag for a request |
| old_addr_o | output | ADDR_W | Tag of the line evicted by the last replace |

## Verification
The bench fills every line and then checks the order of evictions after a mix of reads, updates and drops. A design with a broken recency list would evict the wrong tag. A design that gave no priority to invalid lines would evict a valid line while a dropped line sits unused. Updates and write-drops are checked for the pre-write value on line_o, which catches a store that writes first and then reads. Replacing an address that is already present is checked not to evict anything else, because a duplicate install would leave two matching lines. Misses and illegal command codes are checked to leave line_o and the stored data untouched.

// File: rtl/lcache_pkg.sv
package lcache_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_READ,
        OP_UPDATE,
        OP_READ_DROP,
        OP_WRITE_DROP,
        OP_REPLACE
    } op_e;

    // Per-cycle side effects derived from the command and the lookup result.
    typedef struct packed {
        logic rd;       // capture a line onto the output register
        logic wr;       // write line input into the store
        logic install;  // write tag and set valid
        logic clear;    // clear valid bit
        logic touch;    // move way to most-recently-used
        logic demote;   // move way to least-recently-used
    } act_t;

    function automatic op_e decode_op(input logic req, input logic rw,
                                      input logic inv, input logic rep);
        op_e op;
        op = OP_IDLE;
        if (req && !rep) begin
            case ({rw, inv})
                2'b00:   op = OP_READ;
                2'b10:   op = OP_UPDATE;
                2'b01:   op = OP_READ_DROP;
                default: op = OP_WRITE_DROP;
            endcase
        end else if (!req && rep && !rw && !inv) begin
            op = OP_REPLACE;
        end
        return op;
    endfunction

    function automatic logic is_request(input op_e op);
        return (op == OP_READ) || (op == OP_UPDATE) ||
               (op == OP_READ_DROP) || (op == OP_WRITE_DROP);
    endfunction

    function automatic act_t op_actions(input op_e op, input logic hit);
        act_t a;
        a = '0;
        case (op)
            OP_READ: begin
                a.rd = hit; a.touch = hit;
            end
            OP_UPDATE: begin
                a.rd = hit; a.wr = hit; a.touch = hit;
            end
            OP_READ_DROP: begin
                a.rd = hit; a.clear = hit; a.demote = hit;
            end
            OP_WRITE_DROP: begin
                a.rd = hit; a.wr = hit; a.clear = hit; a.demote = hit;
            end
            OP_REPLACE: begin
                a.rd = 1'b1; a.wr = 1'b1; a.install = 1'b1; a.touch = 1'b1;
            end
            default: a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/lcache_tags.sv
module lcache_tags #(
    parameter int WAYS   = 32,
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [IDX_W-1:0]  lru_way,
    input  logic              install_en,
    input  logic [IDX_W-1:0]  install_idx,
    input  logic              clear_en,
    input  logic [IDX_W-1:0]  clear_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [IDX_W-1:0]  victim_idx,
    output logic [ADDR_W-1:0] rd_tag
);

    logic [ADDR_W-1:0] tags  [WAYS];
    logic [WAYS-1:0]   valid;
    logic [WAYS-1:0]   match;
    logic              any_free;
    logic [IDX_W-1:0]  free_idx;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = valid[w] && (tags[w] == lk_addr);
        end
    endgenerate

    always_comb begin
        hit_idx = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_idx = hit_idx | IDX_W'(w);
        end
    end

    assign hit = |match;

    // Lowest-numbered invalid way wins.
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(w);
            end
        end
    end

    assign victim_idx = any_free ? free_idx : lru_way;
    assign rd_tag     = tags[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
            for (int w = 0; w < WAYS; w++) tags[w] <= '0;
        end else begin
            if (install_en) begin
                tags[install_idx]  <= lk_addr;
                valid[install_idx] <= 1'b1;
            end else if (clear_en) begin
                valid[clear_idx] <= 1'b0;
            end
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R10

    AST_INSTALL_VALID: assert property (@(posedge clk) disable iff (rst)
        install_en |=> valid[$past(install_idx)]); // R7

    AST_CLEAR_INVALID: assert property (@(posedge clk) disable iff (rst)
        (clear_en && !install_en) |=> !valid[$past(clear_idx)]); // R6

endmodule

// File: rtl/lcache_lru.sv
module lcache_lru #(
    parameter int WAYS  = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_way,
    input  logic             demote_en,
    input  logic [IDX_W-1:0] demote_way,
    output logic [IDX_W-1:0] lru_way
);

    // order[0] is least recently used, order[WAYS-1] most recently used.
    logic [IDX_W-1:0] order     [WAYS];
    logic [IDX_W-1:0] order_nxt [WAYS];
    logic [WAYS-1:0]  seen;
    int               t_pos;
    int               d_pos;

    always_comb begin
        t_pos = 0;
        d_pos = 0;
        for (int i = 0; i < WAYS; i++) begin
            if (order[i] == touch_way)  t_pos = i;
            if (order[i] == demote_way) d_pos = i;
        end
    end

    always_comb begin
        for (int i = 0; i < WAYS; i++) order_nxt[i] = order[i];
        if (touch_en) begin
            for (int i = 0; i < WAYS - 1; i++) begin
                if (i >= t_pos) order_nxt[i] = order[i+1];
            end
            order_nxt[WAYS-1] = touch_way;
        end else if (demote_en) begin
            for (int i = 1; i < WAYS; i++) begin
                if (i <= d_pos) order_nxt[i] = order[i-1];
            end
            order_nxt[0] = demote_way;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WAYS; i++) order[i] <= IDX_W'(i);
        end else begin
            for (int i = 0; i < WAYS; i++) order[i] <= order_nxt[i];
        end
    end

    assign lru_way = order[0];

    always_comb begin
        seen = '0;
        for (int i = 0; i < WAYS; i++) seen[order[i]] = 1'b1;
    end

    AST_ORDER_PERMUTATION: assert property (@(posedge clk) disable iff (rst)
        $countones(seen) == WAYS); // R9

    AST_TOUCH_TO_MRU: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> order[WAYS-1] == $past(touch_way)); // R9

    AST_DEMOTE_TO_LRU: assert property (@(posedge clk) disable iff (rst)
        (demote_en && !touch_en) |=> lru_way == $past(demote_way)); // R9

endmodule

// File: rtl/lcache_store.sv
module lcache_store #(
    parameter int DEPTH = 32,
    parameter int W     = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    // Read-first: the captured word is the content before this edge's write.
    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (en) rdata <= mem[idx];
    end

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(rdata)); // R4

endmodule

// File: rtl/lcache_par.sv
module lcache_par
    import lcache_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int ADDR_W = 8,
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              rw_i,
    input  logic              inv_i,
    input  logic              rep_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LINE_W-1:0] line_i,
    output logic [LINE_W-1:0] line_o,
    output logic              hit_o,
    output logic              miss_o,
    output logic [ADDR_W-1:0] old_addr_o
);

    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

    op_e              op;
    act_t             act;
    logic             req_cmd;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] victim_idx;
    logic [IDX_W-1:0] lru_way;
    logic [IDX_W-1:0] tgt_idx;
    logic [ADDR_W-1:0] tgt_tag;

    assign op      = decode_op(req_i, rw_i, inv_i, rep_i);
    assign req_cmd = is_request(op);
    assign act     = op_actions(op, hit);

    // A replace reuses the way of an address already present.
    assign tgt_idx = (op == OP_REPLACE && !hit) ? victim_idx : hit_idx;

    lcache_tags #(.WAYS(LINES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) tags_i (
        .clk         (clk),
        .rst         (rst),
        .lk_addr     (addr_i),
        .lru_way     (lru_way),
        .install_en  (act.install),
        .install_idx (tgt_idx),
        .clear_en    (act.clear),
        .clear_idx   (hit_idx),
        .rd_idx      (tgt_idx),
        .hit         (hit),
        .hit_idx     (hit_idx),
        .victim_idx  (victim_idx),
        .rd_tag      (tgt_tag)
    );

    lcache_lru #(.WAYS(LINES), .IDX_W(IDX_W)) lru_i (
        .clk        (clk),
        .rst        (rst),
        .touch_en   (act.touch),
        .touch_way  (tgt_idx),
        .demote_en  (act.demote),
        .demote_way (hit_idx),
        .lru_way    (lru_way)
    );

    lcache_store #(.DEPTH(LINES), .W(LINE_W), .IDX_W(IDX_W)) store_i (
        .clk   (clk),
        .rst   (rst),
        .en    (act.rd),
        .we    (act.wr),
        .idx   (tgt_idx),
        .wdata (line_i),
        .rdata (line_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_o      <= 1'b0;
            miss_o     <= 1'b0;
            old_addr_o <= '0;
        end else begin
            hit_o  <= req_cmd && hit;
            miss_o <= req_cmd && !hit;
            if (op == OP_REPLACE) old_addr_o <= tgt_tag;
        end
    end

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(hit_o && miss_o)); // R3

    AST_FLAGS_NEED_REQUEST: assert property (@(posedge clk) disable iff (rst)
        !(req_i && !rep_i) |=> (!hit_o && !miss_o)); // R3

    AST_OLD_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(rep_i && !req_i && !rw_i && !inv_i) |=> $stable(old_addr_o)); // R7

    AST_REPLACE_PRESENT_SAME: assert property (@(posedge clk) disable iff (rst)
        (op == OP_REPLACE && hit) |=> old_addr_o == $past(addr_i)); // R10

endmodule

// File: tb/lcache_par_tb.sv
module lcache_par_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LINES  = 32;
    localparam int ADDR_W = 8;
    localparam int LINE_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_i = 1'b0, rw_i = 1'b0, inv_i = 1'b0, rep_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [LINE_W-1:0] line_i = '0;
    logic [LINE_W-1:0] line_o;
    logic              hit_o, miss_o;
    logic [ADDR_W-1:0] old_addr_o;

    int compared = 0;
    int mismatched = 0;

    logic              r_hit, r_miss;
    logic [LINE_W-1:0] r_line;
    logic [ADDR_W-1:0] r_old;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcache_par #(.LINES(LINES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) dut_i (
        .clk(clk), .rst(rst), .req_i(req_i), .rw_i(rw_i), .inv_i(inv_i),
        .rep_i(rep_i), .addr_i(addr_i), .line_i(line_i), .line_o(line_o),
        .hit_o(hit_o), .miss_o(miss_o), .old_addr_o(old_addr_o)
    );

    function automatic logic [ADDR_W-1:0] a_of(input int i);
        return ADDR_W'(8'h40 + i);
    endfunction

    function automatic logic [LINE_W-1:0] d_of(input int i);
        return 32'hC0DE_0000 + LINE_W'(i);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one command for a cycle, then sample its registered results.
    task automatic cmd(input logic rq, input logic rw, input logic iv, input logic rp,
                       input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] d);
        @(negedge clk);
        req_i = rq; rw_i = rw; inv_i = iv; rep_i = rp; addr_i = a; line_i = d;
        @(negedge clk);
        r_hit = hit_o; r_miss = miss_o; r_line = line_o; r_old = old_addr_o;
        req_i = 0; rw_i = 0; inv_i = 0; rep_i = 0; line_i = '0;
    endtask

    task automatic t_reset;
        chk("R1 hit after reset", 32'(hit_o), 0);
        chk("R1 miss after reset", 32'(miss_o), 0);
        chk("R1 line after reset", line_o, 0);
        chk("R1 old_addr after reset", 32'(old_addr_o), 0);
        cmd(1, 0, 0, 0, 8'h10, '0);
        chk("R1 R3 empty cache misses", 32'({r_hit, r_miss}), 32'b01);
    endtask

    task automatic t_fill;
        for (int i = 0; i < LINES; i++) begin
            cmd(0, 0, 0, 1, a_of(i), d_of(i));
            if (i == 0 || i == LINES - 1) begin
                chk("R8 fill evicts reset tag", 32'(r_old), 0);
                chk("R7 replace raises no flag", 32'({r_hit, r_miss}), 0);
            end
        end
        for (int i = 0; i < LINES; i++) begin
            cmd(1, 0, 0, 0, a_of(i), '0);
            if (i % 8 == 0 || i == LINES - 1) begin
                chk("R3 filled line hits", 32'({r_hit, r_miss}), 32'b10);
                chk("R4 R7 read returns installed data", r_line, d_of(i));
            end
        end
    endtask

    task automatic t_lru;
        cmd(0, 0, 0, 1, 8'h80, 32'hAAAA_0080);
        chk("R9 evicts least recent tag", 32'(r_old), 32'(a_of(0)));
        chk("R9 evicted content", r_line, d_of(0));
        cmd(1, 0, 0, 0, a_of(1), '0);
        cmd(0, 0, 0, 1, 8'h81, 32'hAAAA_0081);
        chk("R9 read refresh skips way", 32'(r_old), 32'(a_of(2)));
        cmd(1, 0, 0, 0, 8'h80, '0);
        chk("R7 new address hits with new data", r_line, 32'hAAAA_0080);
    endtask

    task automatic t_update;
        cmd(1, 1, 0, 0, a_of(5), 32'h5555_1111);
        chk("R5 update returns old content", r_line, d_of(5));
        chk("R5 update hit flag", 32'({r_hit, r_miss}), 32'b10);
        cmd(1, 0, 0, 0, a_of(5), '0);
        chk("R5 update stored new content", r_line, 32'h5555_1111);
    endtask

    task automatic t_drop;
        cmd(1, 0, 1, 0, a_of(6), '0);
        chk("R6 read-drop returns content", r_line, d_of(6));
        cmd(1, 0, 0, 0, a_of(6), '0);
        chk("R6 dropped address misses", 32'({r_hit, r_miss}), 32'b01);
        cmd(1, 1, 1, 0, a_of(7), 32'h7777_BEEF);
        chk("R6 write-drop returns old content", r_line, d_of(7));
        cmd(1, 0, 0, 0, a_of(7), '0);
        chk("R6 write-dropped address misses", 32'({r_hit, r_miss}), 32'b01);
        cmd(0, 0, 0, 1, 8'h90, 32'h9090_0000);
        chk("R8 invalid way chosen over LRU", 32'(r_old), 32'(a_of(6)));
        cmd(0, 0, 0, 1, 8'h91, 32'h9191_0000);
        chk("R8 next invalid way", 32'(r_old), 32'(a_of(7)));
        chk("R6 write-drop data was stored", r_line, 32'h7777_BEEF);
    endtask

    task automatic t_replace_present;
        cmd(0, 0, 0, 1, a_of(3), 32'h3333_0000);
        chk("R10 present replace returns own tag", 32'(r_old), 32'(a_of(3)));
        chk("R10 present replace returns old data", r_line, d_of(3));
        cmd(1, 0, 0, 0, a_of(3), '0);
        chk("R10 present replace new data", r_line, 32'h3333_0000);
        cmd(1, 0, 0, 0, a_of(4), '0);
        chk("R10 neighbour still present", 32'({r_hit, r_miss}), 32'b10);
        // Order now starts with way 8 (way 4 was just read).
        cmd(0, 0, 0, 1, 8'hA0, 32'hA0A0_0000);
        chk("R9 order after mixed commands", 32'(r_old), 32'(a_of(8)));
    endtask

    task automatic t_miss_and_illegal;
        logic [LINE_W-1:0] held;
        cmd(1, 0, 0, 0, a_of(9), '0);
        held = r_line;
        cmd(1, 1, 0, 0, 8'hEE, 32'hDEAD_0001);
        chk("R11 update miss flag", 32'({r_hit, r_miss}), 32'b01);
        chk("R4 R11 line_o holds on miss", r_line, held);
        cmd(1, 0, 0, 0, 8'hEE, '0);
        chk("R11 miss did not allocate", 32'({r_hit, r_miss}), 32'b01);
        cmd(1, 1, 0, 1, a_of(10), 32'hDEAD_0002);
        chk("R2 req+replace raises nothing", 32'({r_hit, r_miss}), 0);
        chk("R2 req+replace leaves line_o", r_line, held);
        chk("R2 R7 old_addr holds", 32'(r_old), 32'(a_of(8)));
        cmd(0, 1, 1, 0, a_of(10), 32'hDEAD_0003);
        chk("R2 R3 no-request code raises nothing", 32'({r_hit, r_miss}), 0);
        cmd(1, 0, 0, 0, a_of(10), '0);
        chk("R2 illegal codes left data", r_line, d_of(10));
        @(negedge clk);
        chk("R3 idle cycle clears flags", 32'({hit_o, miss_o}), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        mismatched++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill();
        t_lru();
        t_update();
        t_drop();
        t_replace_present();
        t_miss_and_illegal();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule